// File: doc/BRIEF.md
# Framed Synchronous Serial Port

This block moves fixed-length words between a parallel interface and a four-wire serial link: bit clock, frame sync, transmit data and receive data. On the parallel side a transmit word is handed over with a valid/ready handshake into a one-word holding register. A received word is presented with a valid flag that stays up until the consumer takes it. One bit clock drives both shift registers. Outgoing bits are launched on the rising edge of the bit clock, and incoming bits are sampled on the falling edge.

A control register selects the framing. The frame sync can last a whole word or a single bit. A word-length sync can lead the data by one bit. Bits can go out most or least significant first. The bit clock can come from an internal divider of the system clock or from the pin. The frame sync can be generated internally or detected on the pin. Each internally timed frame is the word followed by a short idle gap. An externally timed frame starts only when a sync is seen.

Top module: `sync_serial_port`

## Requirements
- R1: After reset all control fields are zero and the port is idle. `tx_ready` is 1, and `rx_valid`, `underrun`, `sck_out`, `sck_oe`, `fs_out`, `fs_oe` and `txd` are all 0.
- R2: The control word is written through `cfg_wdata` when `cfg_we` is high. Bit 0 enables the port. With internal sync (bit 4 = 1) and word-length sync, the sync is high for exactly the `WORD_W` bits of the word, starting with the first data bit, while bit 9 is 0. When bit 9 is 1 the sync rises one bit clock earlier, in the last idle bit before the word, and falls one bit earlier.
- R3: With bit-length sync, the internal sync is high only during the first data bit of each frame, and bit 9 has no effect.
- R4: Bit 6 = 0 sends and assembles words most significant bit first. Bit 6 = 1 sends and assembles them least significant bit first.
- R5: The sync length field is bits 8:7. The codes 00 and 01 select word-length sync, and the codes 10 and 11 select bit-length sync.
- R6: With bit 5 = 1 the bit clock is the system clock divided by 2·`div_half`, it is driven on `sck_out`, and `sck_oe` is 1. With bit 5 = 0, `sck_oe` is 0, `sck_out` stays 0, and the edges of `sck_in` clock both directions.
- R7: With bit 4 = 0, `fs_oe` is 0, `fs_out` stays 0, and a rising edge on `fs_in`, sampled on a falling bit clock edge, starts one frame. The first data bit follows in the next bit period, or one period later still when word-length sync and bit 9 are both selected.
- R8: A received word appears on `rx_data` with `rx_valid` high after its last bit is sampled. `rx_valid` stays high until a cycle with `rx_ready` high.
- R9: If the holding register is empty when a frame starts, the frame sends all zeros and `underrun` is set. `underrun` then stays set until reset.
- R10: `tx_ready` is low while the holding register is full, including while the port is disabled. The register empties when a frame starts. A word accepted in the very cycle a frame starts with an empty register is kept for the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 10 | Control word: 9 early sync, 8:7 sync length, 6 LSB first, 5 internal clock, 4 internal sync, 0 enable |
| div_half | input | DIV_W | Half period of the internal bit clock in system clocks (at least 1) |
| tx_data | input | WORD_W | Word to transmit |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Holding register can take a word |
| rx_data | output | WORD_W | Last received word |
| rx_valid | output | 1 | Received word waiting |
| rx_ready | input | 1 | Consumer takes the received word |
| underrun | output | 1 | Sticky: a frame started with no word to send |
| sck_in | input | 1 | Bit clock from the pin |
| sck_out | output | 1 | Internally generated bit clock |
| sck_oe | output | 1 | Bit clock pin drive enable |
| fs_in | input | 1 | Frame sync from the pin |
| fs_out | output | 1 | Internally generated frame sync |
| fs_oe | output | 1 | Frame sync pin drive enable |
| txd | output | 1 | Serial transmit data |
| rxd | input | 1 | Serial receive data |

## Verification
The transmit handshake and the frame start can land on the same system clock edge. The bench sets this up by enabling the port and offering a word so that the handshake completes exactly on the first rising bit clock edge. The expected outcome is a zero frame with `underrun` set, followed by the offered word intact in the next frame. This outcome is judged by a scoreboard that expects a zero word ahead of the real one. The bench feeds its own `rxd` back from `txd`, so words that go out wrongly come back wrongly. Separate logs of `fs_out` and `txd`, taken on each falling bit clock edge, pin down sync placement and bit order per bit period.

// File: rtl/sync_serial_port.sv
module sync_serial_port #(
  parameter int WORD_W   = 16,
  parameter int GAP_BITS = 4,
  parameter int DIV_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [9:0]        cfg_wdata,
  input  logic [DIV_W-1:0]  div_half,
  input  logic [WORD_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic              underrun,
  input  logic              sck_in,
  output logic              sck_out,
  output logic              sck_oe,
  input  logic              fs_in,
  output logic              fs_out,
  output logic              fs_oe,
  output logic              txd,
  input  logic              rxd
);

  localparam int PER = WORD_W + GAP_BITS;
  localparam int PW  = $clog2(PER);
  localparam logic [PW-1:0] POS_END  = PW'(PER - 1);
  localparam logic [PW-1:0] POS_PRE  = PW'(PER - 2);
  localparam logic [PW-1:0] POS_LAST = PW'(WORD_W - 1);
  localparam logic [PW-1:0] POS_WLEN = PW'(WORD_W);

  logic       en, early_bit, lsb_first, clk_int, sync_int;
  logic [1:0] sync_len;
  logic       unused_cfg;
  assign unused_cfg = ^cfg_wdata[3:1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {early_bit, sync_len, lsb_first, clk_int, sync_int, en} <= '0;
    else if (cfg_we) begin
      {early_bit, sync_len, lsb_first, clk_int, sync_int} <= cfg_wdata[9:4];
      en <= cfg_wdata[0];
    end

  wire word_sync = !sync_len[1];
  wire lead      = early_bit & word_sync;

  // bit clock: internal divider or synchronized pin
  logic [DIV_W-1:0] div_cnt;
  logic             sck_q;
  logic [2:0]       sck_sync;
  wire div_hit = ({1'b0, div_cnt} + 1'b1) >= {1'b0, div_half};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      div_cnt <= '0;
      sck_q   <= 1'b0;
    end else if (!en || !clk_int) begin
      div_cnt <= '0;
      sck_q   <= 1'b0;
    end else if (div_hit) begin
      div_cnt <= '0;
      sck_q   <= !sck_q;
    end else div_cnt <= div_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sck_sync <= '0;
    else        sck_sync <= {sck_sync[1:0], sck_in};

  wire rise = en & (clk_int ? (div_hit & !sck_q) : (sck_sync[1] & !sck_sync[2]));
  wire fall = en & (clk_int ? (div_hit &  sck_q) : (!sck_sync[1] & sck_sync[2]));

  // frame position
  logic [PW-1:0] pos;
  logic          armed, live, fs_prev;
  wire at_end      = pos == POS_END;
  wire in_word     = pos < POS_WLEN;
  wire frame_start = rise & at_end & (sync_int | armed);
  wire sync_seen   = fall & !sync_int & fs_in & !fs_prev;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pos <= POS_END; armed <= 1'b0; live <= 1'b0; fs_prev <= 1'b0;
    end else if (!en) begin
      pos <= POS_END; armed <= 1'b0; live <= 1'b0;
    end else begin
      if (fall) fs_prev <= fs_in;
      if (sync_seen) begin
        pos   <= lead ? POS_PRE : POS_END;
        armed <= 1'b1;
      end else if (frame_start) begin
        pos   <= '0;
        armed <= 1'b0;
        live  <= 1'b1;
      end else if (rise && !at_end) pos <= pos + 1'b1;
    end

  // transmit path
  logic [WORD_W-1:0] tx_sr, tx_hold;
  logic              tx_full, urun;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_sr <= '0; tx_hold <= '0; tx_full <= 1'b0; urun <= 1'b0;
    end else begin
      if (frame_start) begin
        tx_sr <= tx_full ? tx_hold : '0;
        if (tx_full) tx_full <= 1'b0;
        else         urun    <= 1'b1;
      end else if (rise) tx_sr <= lsb_first ? (tx_sr >> 1) : (tx_sr << 1);
      if (tx_valid && !tx_full) begin
        tx_hold <= tx_data;
        tx_full <= 1'b1;
      end
    end

  assign txd      = in_word & (lsb_first ? tx_sr[0] : tx_sr[WORD_W-1]);
  assign tx_ready = !tx_full;
  assign underrun = urun;

  // receive path
  logic [WORD_W-1:0] rx_sr, rx_q;
  logic              rx_v;
  wire [WORD_W-1:0] rx_next = lsb_first ? {rxd, rx_sr[WORD_W-1:1]}
                                        : {rx_sr[WORD_W-2:0], rxd};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_sr <= '0; rx_q <= '0; rx_v <= 1'b0;
    end else begin
      if (rx_v && rx_ready) rx_v <= 1'b0;
      if (fall && in_word) begin
        rx_sr <= rx_next;
        if (pos == POS_LAST) begin
          rx_q <= rx_next;
          rx_v <= 1'b1;
        end
      end
    end

  assign rx_data  = rx_q;
  assign rx_valid = rx_v;

  // pins
  wire fs_word = lead ? ((at_end & live) | (pos < POS_LAST)) : in_word;
  assign fs_out  = en & sync_int & (word_sync ? fs_word : (pos == '0));
  assign fs_oe   = sync_int;
  assign sck_out = sck_q;
  assign sck_oe  = clk_int;

endmodule

// File: rtl/ssp_checker.sv
module ssp_checker (
  input logic clk,
  input logic rst_n,
  input logic tx_valid,
  input logic tx_ready,
  input logic rx_valid,
  input logic rx_ready,
  input logic underrun,
  input logic sck_out,
  input logic sck_oe
);

  assert_ready_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);

  assert_rx_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> rx_valid);

  assert_underrun_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> underrun);

  assert_pin_clock_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!sck_oe && !$past(sck_oe)) |-> !sck_out);

endmodule

bind sync_serial_port ssp_checker u_ssp_checker (
  .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .rx_valid(rx_valid), .rx_ready(rx_ready), .underrun(underrun),
  .sck_out(sck_out), .sck_oe(sck_oe)
);

// File: tb/sync_serial_port_bench.sv
module sync_serial_port_bench;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0;
  logic [9:0] cfg_wdata = '0;
  logic [7:0] div_half = 8'd2;
  logic [15:0] tx_data = '0;
  logic tx_valid = 0, rx_ready = 1;
  logic [15:0] rx_data;
  logic tx_ready, rx_valid, underrun, sck_out, sck_oe, fs_out, fs_oe, txd;
  logic sck_drv = 0, fs_drv = 0, rxd_drv = 0, loop_en = 1, sck_run = 0;
  wire rxd = loop_en ? txd : rxd_drv;

  int n_checks = 0, n_fail = 0;
  bit done = 0;
  logic [15:0] exp_q[$];
  logic fs_log[64];
  logic tx_log[64];
  int log_n = 0;

  always #4 clk = ~clk;

  sync_serial_port u_sync_serial_port (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .div_half(div_half), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .underrun(underrun), .sck_in(sck_drv),
    .sck_out(sck_out), .sck_oe(sck_oe), .fs_in(fs_drv), .fs_out(fs_out),
    .fs_oe(fs_oe), .txd(txd), .rxd(rxd)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always begin
    repeat (8) @(negedge clk);
    sck_drv = sck_run ? ~sck_drv : 1'b0;
  end

  always @(negedge sck_out)
    if (log_n < 64) begin
      fs_log[log_n] = fs_out;
      tx_log[log_n] = txd;
      log_n++;
    end

  // monitor: pops expected words as the port delivers them
  always @(negedge clk)
    if (rst_n && rx_valid && rx_ready) begin
      if (exp_q.size() > 0) check("R8 received word", 32'(rx_data), 32'(exp_q.pop_front()));
      else begin
        check("R9 underrun frame carries zeros", 32'(rx_data), 32'd0);
        check("R9 underrun flag with zero frame", 32'(underrun), 32'd1);
      end
    end

  task automatic cfg(input logic [9:0] v);
    @(negedge clk);
    cfg_we = 1; cfg_wdata = v; log_n = 0;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic send(input logic [15:0] w);
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    tx_data = w; tx_valid = 1;
    exp_q.push_back(w);
    @(negedge clk);
    tx_valid = 0;
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // mode 0: word sync, 1: early word sync, 2: bit sync
  task automatic check_frame(input string tag, input int mode, input bit lsb,
                             input logic [15:0] w0, input logic [15:0] w1);
    int bad_fs = -1;
    int bad_tx = -1;
    logic e_fs, e_tx;
    check({tag, " sample count"}, 32'(log_n >= 40), 32'd1);
    for (int i = 0; i < 40; i++) begin
      int p = i % 20;
      logic [15:0] w = (i < 20) ? w0 : w1;
      case (mode)
        0: e_fs = p < 16;
        1: e_fs = (p == 19) || (p < 15);
        default: e_fs = (p == 0);
      endcase
      e_tx = (p < 16) ? (lsb ? w[p] : w[15-p]) : 1'b0;
      if (fs_log[i] !== e_fs && bad_fs < 0) bad_fs = i;
      if (tx_log[i] !== e_tx && bad_tx < 0) bad_tx = i;
    end
    check({tag, " sync bit position"}, 32'(bad_fs), 32'hffffffff);
    check({tag, " data bit position"}, 32'(bad_tx), 32'hffffffff);
  endtask

  task automatic ext_frame(input bit early, input logic [15:0] w);
    for (int i = 0; i < 19; i++) begin
      @(posedge sck_out);
      if (early) begin
        fs_drv  = (i < 16);
        rxd_drv = (i >= 2 && i < 18) ? w[17-i] : 1'b0;
      end else begin
        fs_drv  = (i == 0);
        rxd_drv = (i >= 1 && i < 17) ? w[16-i] : 1'b0;
      end
    end
    @(posedge sck_out);
    fs_drv = 0; rxd_drv = 0;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    wait_clk(5);
    rst_n = 1;
    wait_clk(1);
    check("R1 tx_ready", 32'(tx_ready), 32'd1);
    check("R1 rx_valid", 32'(rx_valid), 32'd0);
    check("R1 underrun", 32'(underrun), 32'd0);
    check("R1 sck_oe", 32'(sck_oe), 32'd0);
    check("R1 fs_oe", 32'(fs_oe), 32'd0);
    check("R1 sck_out", 32'(sck_out), 32'd0);
    check("R1 fs_out", 32'(fs_out), 32'd0);
    check("R1 txd", 32'(txd), 32'd0);

    // handshake lands on the first frame start with an empty register
    cfg(10'h031);
    exp_q.push_back(16'h0000);
    send(16'hD00D);
    check("R9 flag set by empty frame start", 32'(underrun), 32'd1);
    check("R10 coincident word held", 32'(tx_ready), 32'd0);
    wait_clk(200);
    cfg(10'h000);
    wait_clk(20);
    check("R10 coincident words delivered", 32'(exp_q.size()), 32'd0);

    // normal word sync, MSB first, internal clock and sync
    send(16'hA5C3);
    check("R10 full while disabled", 32'(tx_ready), 32'd0);
    cfg(10'h031);
    wait_clk(10);
    check("R10 emptied at frame start", 32'(tx_ready), 32'd1);
    check("R6 internal clock drives pin", 32'(sck_oe), 32'd1);
    check("R7 internal sync drives pin", 32'(fs_oe), 32'd1);
    send(16'h1234);
    send(16'h0F0F);
    wait_clk(380);
    check_frame("R2 normal word sync R4 msb first", 0, 1'b0, 16'hA5C3, 16'h1234);
    cfg(10'h000);
    wait_clk(20);

    // bit sync, early bit set but ignored, LSB first, length code 11
    send(16'h8001);
    cfg(10'h3F1);
    send(16'h6C39);
    wait_clk(180);
    check_frame("R3 bit sync R4 lsb first R5 code 11", 2, 1'b1, 16'h8001, 16'h6C39);
    cfg(10'h000);
    wait_clk(20);

    // early word sync
    send(16'hB44B);
    cfg(10'h231);
    send(16'h7E81);
    wait_clk(180);
    check_frame("R2 early word sync", 1, 1'b0, 16'hB44B, 16'h7E81);
    cfg(10'h000);
    wait_clk(20);

    // length code 01 behaves as word sync
    cfg(10'h0B1);
    wait_clk(180);
    check_frame("R5 code 01 word sync", 0, 1'b0, 16'h0000, 16'h0000);
    cfg(10'h000);
    wait_clk(20);
    check("R8 queue drained", 32'(exp_q.size()), 32'd0);

    // external sync, bit length then early word length
    loop_en = 0;
    rx_ready = 0;
    exp_q.push_back(16'h3C5A);
    cfg(10'h121);
    wait_clk(4);
    check("R7 sync pin released", 32'(fs_oe), 32'd0);
    ext_frame(1'b0, 16'h3C5A);
    wait_clk(20);
    check("R8 valid held without ready", 32'(rx_valid), 32'd1);
    check("R7 no internal sync", 32'(fs_out), 32'd0);
    rx_ready = 1;
    wait_clk(5);
    check("R8 valid cleared after ready", 32'(rx_valid), 32'd0);
    exp_q.push_back(16'hC35A);
    cfg(10'h221);
    ext_frame(1'b1, 16'hC35A);
    wait_clk(20);
    cfg(10'h000);
    wait_clk(10);
    check("R7 external sync words received", 32'(exp_q.size()), 32'd0);
    loop_en = 1;

    // clock from the pin
    sck_run = 1;
    send(16'h5AA5);
    cfg(10'h011);
    send(16'h9009);
    wait_clk(300);
    check("R6 pin clock output enable", 32'(sck_oe), 32'd0);
    check("R6 pin clock no internal clock", 32'(sck_out), 32'd0);
    wait_clk(450);
    check("R6 pin clock words received", 32'(exp_q.size()), 32'd0);
    cfg(10'h000);
    sck_run = 0;
    wait_clk(20);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule